// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block sequences the low-power states of a small microcontroller core. The instruction decoder sends it a one-cycle strobe when a halt or a stop instruction executes. The block then moves among three states: run, halt and clock-stop. From its state and the level of the chip-enable pin it drives the program counter hold and clear, the initialization pulses for the system and control registers, one run enable for each peripheral, the PLL enable, and the port direction and hold controls.

The chip-enable level decides three things. It decides whether a stop is honoured. It decides whether the PLL keeps running during halt. It decides whether a power-down clears the program counter and reinitializes the control registers.

In halt, fetch is frozen at the halt address while every peripheral keeps running with its current settings. Clock-stop is a full power-down: peripherals are disabled, the program counter is forced to zero, and the register initialization fires once. A wake request returns either low-power state to run.

Named states are RUN (`2'b00`), HALT (`2'b01`) and CSTOP (`2'b10`). The transitions are:
- RUN→HALT on a halt strobe.
- RUN→CSTOP on a stop strobe with chip-enable low.
- RUN→RUN on a stop strobe with chip-enable high.
- HALT→RUN on a wake request.
- CSTOP→RUN on a wake request.
- Any state→RUN on reset.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: `state_o` encodes RUN=2'b00, HALT=2'b01, CSTOP=2'b10. A synchronous active-low reset gives the following one cycle after the sampling edge: RUN, all `periph_en` high, `pll_en` high, `pc_hold`=0, `pc_clear`=0, no init pulse, `gpio_force_in`=0 and `out_hold`=0.
- R2: A halt strobe in RUN (with no stop strobe) enters HALT at the next edge. In HALT, `pc_hold`=1, `pc_clear`=0 and all `periph_en` stay high.
- R3: A stop strobe in RUN while `ce_pin`=1 is a no-operation. The state stays RUN and no init pulse is produced.
- R4: A stop strobe in RUN while `ce_pin`=0 enters CSTOP at the next edge. In CSTOP, `pc_hold`=1, `pc_clear`=1 and all `periph_en` are 0.
- R5: `sysreg_init` and `ctrlreg_init` are high together for exactly the first CSTOP cycle after an accepted stop, and at no other time. Halt never raises them.
- R6: `pll_en` is 1 in RUN, equals the live `ce_pin` level in HALT, and is 0 in CSTOP.
- R7: `gpio_force_in` (all bits) and `out_hold` are 1 in CSTOP and 0 in RUN and HALT.
- R8: `wake_req` in HALT or CSTOP returns the state to RUN at the next edge. In RUN, `wake_req` has no effect.
- R9: When halt and stop strobes arrive in the same RUN cycle, the stop wins. With `ce_pin`=0 the next state is CSTOP. With `ce_pin`=1 the state stays RUN and the halt is dropped.
- R10: In HALT or CSTOP, halt and stop strobes without a wake request leave the state unchanged and produce no init pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| halt_stb | input | 1 | Halt instruction executed (one cycle) |
| stop_stb | input | 1 | Stop instruction executed (one cycle) |
| ce_pin | input | 1 | Chip-enable pin level |
| wake_req | input | 1 | Wake-up request |
| state_o | output | 2 | Current mode state |
| pc_hold | output | 1 | Freeze program counter |
| pc_clear | output | 1 | Force program counter to 0000H |
| sysreg_init | output | 1 | System register initialization pulse |
| ctrlreg_init | output | 1 | Control register initialization pulse |
| periph_en | output | NUM_PERIPH | Per-peripheral run enables |
| pll_en | output | 1 | PLL synthesizer enable |
| gpio_force_in | output | NUM_BIDIR | Force bidirectional ports to input |
| out_hold | output | 1 | Hold dedicated output ports |

## Verification
The bench targets four corner cases.
- A stop arriving while chip-enable is high: a design that ignored the pin would power down and fire the init pulse.
- A halt and a stop in the same cycle: a wrong priority would land in HALT instead of CSTOP, or would take the halt after a dropped stop.
- Chip-enable toggling during halt: a design that latched the pin, or ignored it, would leave the PLL running or stopped wrongly.
- Strobes arriving while already halted or stopped: such a design would re-enter a state or pulse the register initialization a second time. The bench also checks that the pulse lasts one cycle, since a level-style init would hold the registers in reset for the whole power-down.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
    typedef enum logic [1:0] {
        PM_RUN   = 2'b00,
        PM_HALT  = 2'b01,
        PM_CSTOP = 2'b10
    } pm_state_e;
endpackage

// File: rtl/pwr_strobe_arb.sv
// Resolves simultaneous instruction strobes: stop takes priority; a stop
// with chip-enable high is a no-operation and swallows any halt beside it.
module pwr_strobe_arb (
    input  logic halt_stb,
    input  logic stop_stb,
    input  logic ce_pin,
    output logic go_stop,
    output logic go_halt
);
    always_comb begin
        go_stop = stop_stb & ~ce_pin;
        go_halt = halt_stb & ~stop_stb;
    end
endmodule

// File: rtl/pwr_state_fsm.sv
module pwr_state_fsm
    import pwr_mode_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      go_stop,
    input  logic      go_halt,
    input  logic      wake_req,
    output pm_state_e state_q,
    output logic      init_pulse
);
    pm_state_e state_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PM_RUN: begin
                if (go_stop)      state_d = PM_CSTOP;
                else if (go_halt) state_d = PM_HALT;
            end
            PM_HALT: begin
                if (wake_req)     state_d = PM_RUN;
            end
            PM_CSTOP: begin
                if (wake_req)     state_d = PM_RUN;
            end
            default:              state_d = PM_RUN;
        endcase
    end

    // state register and one-shot register initialization
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= PM_RUN;
            init_pulse <= 1'b0;
        end else begin
            state_q    <= state_d;
            init_pulse <= (state_q == PM_RUN) && go_stop;
        end
    end
endmodule

// File: rtl/pwr_out_decode.sv
module pwr_out_decode
    import pwr_mode_pkg::*;
#(
    parameter int NUM_PERIPH = 8,
    parameter int NUM_BIDIR  = 4
) (
    input  pm_state_e              state_q,
    input  logic                   ce_pin,
    output logic                   pc_hold,
    output logic                   pc_clear,
    output logic                   pll_en,
    output logic                   out_hold,
    output logic [NUM_PERIPH-1:0]  periph_en,
    output logic [NUM_BIDIR-1:0]   gpio_force_in
);
    logic periph_run;
    logic port_freeze;

    always_comb begin
        pc_hold     = 1'b0;
        pc_clear    = 1'b0;
        pll_en      = 1'b1;
        periph_run  = 1'b1;
        port_freeze = 1'b0;
        unique case (state_q)
            PM_RUN: ;
            PM_HALT: begin
                pc_hold = 1'b1;
                pll_en  = ce_pin;
            end
            PM_CSTOP: begin
                pc_hold     = 1'b1;
                pc_clear    = 1'b1;
                pll_en      = 1'b0;
                periph_run  = 1'b0;
                port_freeze = 1'b1;
            end
            default: ;
        endcase
        out_hold = port_freeze;
    end

    for (genvar gp = 0; gp < NUM_PERIPH; gp++) begin : g_periph
        assign periph_en[gp] = periph_run;
    end

    for (genvar gb = 0; gb < NUM_BIDIR; gb++) begin : g_bidir
        assign gpio_force_in[gb] = port_freeze;
    end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pwr_mode_pkg::*;
#(
    parameter int NUM_PERIPH = 8,
    parameter int NUM_BIDIR  = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  halt_stb,
    input  logic                  stop_stb,
    input  logic                  ce_pin,
    input  logic                  wake_req,
    output logic [1:0]            state_o,
    output logic                  pc_hold,
    output logic                  pc_clear,
    output logic                  sysreg_init,
    output logic                  ctrlreg_init,
    output logic [NUM_PERIPH-1:0] periph_en,
    output logic                  pll_en,
    output logic [NUM_BIDIR-1:0]  gpio_force_in,
    output logic                  out_hold
);
    logic      go_stop;
    logic      go_halt;
    logic      init_pulse;
    pm_state_e state_q;

    pwr_strobe_arb u_arb (
        .halt_stb (halt_stb),
        .stop_stb (stop_stb),
        .ce_pin   (ce_pin),
        .go_stop  (go_stop),
        .go_halt  (go_halt)
    );

    pwr_state_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .go_stop    (go_stop),
        .go_halt    (go_halt),
        .wake_req   (wake_req),
        .state_q    (state_q),
        .init_pulse (init_pulse)
    );

    pwr_out_decode #(
        .NUM_PERIPH (NUM_PERIPH),
        .NUM_BIDIR  (NUM_BIDIR)
    ) u_dec (
        .state_q       (state_q),
        .ce_pin        (ce_pin),
        .pc_hold       (pc_hold),
        .pc_clear      (pc_clear),
        .pll_en        (pll_en),
        .out_hold      (out_hold),
        .periph_en     (periph_en),
        .gpio_force_in (gpio_force_in)
    );

    assign state_o      = state_q;
    assign sysreg_init  = init_pulse;
    assign ctrlreg_init = init_pulse;
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk #(
    parameter int NUM_PERIPH = 8,
    parameter int NUM_BIDIR  = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  halt_stb,
    input logic                  stop_stb,
    input logic                  ce_pin,
    input logic                  wake_req,
    input logic [1:0]            state_o,
    input logic                  pc_clear,
    input logic                  sysreg_init,
    input logic                  ctrlreg_init,
    input logic [NUM_PERIPH-1:0] periph_en,
    input logic                  pll_en,
    input logic [NUM_BIDIR-1:0]  gpio_force_in,
    input logic                  out_hold
);
    assert_reset_run_R1: assert property (@(posedge clk)
        !rst_n |=> state_o == 2'b00);

    assert_halt_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'b00 && halt_stb && !stop_stb) |=> state_o == 2'b01);

    assert_stop_nop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'b00 && stop_stb && ce_pin) |=> (state_o == 2'b00 && !sysreg_init));

    assert_cstop_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'b00 && stop_stb && !ce_pin) |=> (state_o == 2'b10 && pc_clear && periph_en == '0));

    assert_init_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sysreg_init |=> !sysreg_init);

    assert_init_in_cstop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sysreg_init |-> (state_o == 2'b10 && ctrlreg_init));

    assert_pll_halt_R6: assert property (@(posedge clk) disable iff (!rst_n)
        state_o == 2'b01 |-> pll_en == ce_pin);

    assert_ports_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
        state_o != 2'b10 |-> (gpio_force_in == '0 && !out_hold));

    assert_wake_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o != 2'b00 && wake_req) |=> state_o == 2'b00);

    assert_halt_stay_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'b01 && !wake_req) |=> (state_o == 2'b01 && !sysreg_init));
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk #(
    .NUM_PERIPH (NUM_PERIPH),
    .NUM_BIDIR  (NUM_BIDIR)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .halt_stb      (halt_stb),
    .stop_stb      (stop_stb),
    .ce_pin        (ce_pin),
    .wake_req      (wake_req),
    .state_o       (state_o),
    .pc_clear      (pc_clear),
    .sysreg_init   (sysreg_init),
    .ctrlreg_init  (ctrlreg_init),
    .periph_en     (periph_en),
    .pll_en        (pll_en),
    .gpio_force_in (gpio_force_in),
    .out_hold      (out_hold)
);

// File: tb/tb_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module tb_pwr_mode_ctrl;
    localparam int NP = 8;
    localparam int NB = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          halt_stb = 1'b0;
    logic          stop_stb = 1'b0;
    logic          ce_pin = 1'b1;
    logic          wake_req = 1'b0;
    logic [1:0]    state_o;
    logic          pc_hold, pc_clear, sysreg_init, ctrlreg_init, pll_en, out_hold;
    logic [NP-1:0] periph_en;
    logic [NB-1:0] gpio_force_in;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    // reference model state
    int    m_state = 0;
    bit    m_init  = 1'b0;
    string m_cause = "R1";

    always #10 clk = ~clk;

    pwr_mode_ctrl #(.NUM_PERIPH(NP), .NUM_BIDIR(NB)) dut (
        .clk(clk), .rst_n(rst_n), .halt_stb(halt_stb), .stop_stb(stop_stb),
        .ce_pin(ce_pin), .wake_req(wake_req), .state_o(state_o),
        .pc_hold(pc_hold), .pc_clear(pc_clear), .sysreg_init(sysreg_init),
        .ctrlreg_init(ctrlreg_init), .periph_en(periph_en), .pll_en(pll_en),
        .gpio_force_in(gpio_force_in), .out_hold(out_hold)
    );

    // behavioural reference, updated on every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_init = 1'b0; m_cause = "R1";
        end else begin
            m_init = 1'b0;
            if (m_state == 0) begin
                if (stop_stb && !ce_pin) begin
                    m_state = 2; m_init = 1'b1;
                    m_cause = halt_stb ? "R9" : "R4";
                end else if (stop_stb) begin
                    m_cause = halt_stb ? "R9" : "R3";
                end else if (halt_stb) begin
                    m_state = 1; m_cause = "R2";
                end else if (wake_req) begin
                    m_cause = "R8";
                end
            end else begin
                if (wake_req) begin
                    m_state = 0; m_cause = "R8";
                end else if (halt_stb || stop_stb) begin
                    m_cause = "R10";
                end
            end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // compare on every falling edge
    always @(negedge clk) begin
        if (!done) begin
            string preq;
            preq = (m_state == 0) ? "R1" : (m_state == 1) ? "R2" : "R4";
            chk(m_cause, "state", int'(state_o), m_state);
            chk(preq, "pc_hold", int'(pc_hold), (m_state != 0) ? 1 : 0);
            chk(preq, "pc_clear", int'(pc_clear), (m_state == 2) ? 1 : 0);
            chk(preq, "periph_en", int'(periph_en), (m_state == 2) ? 0 : (1 << NP) - 1);
            chk("R5", "sysreg_init", int'(sysreg_init), int'(m_init));
            chk("R5", "ctrlreg_init", int'(ctrlreg_init), int'(m_init));
            chk("R6", "pll_en", int'(pll_en),
                (m_state == 0) ? 1 : (m_state == 1) ? int'(ce_pin) : 0);
            chk("R7", "gpio_force_in", int'(gpio_force_in), (m_state == 2) ? (1 << NB) - 1 : 0);
            chk("R7", "out_hold", int'(out_hold), (m_state == 2) ? 1 : 0);
        end
    end

    // apply one cycle of inputs shortly after a rising edge
    task automatic step(input bit h, input bit s, input bit c, input bit w);
        @(posedge clk); #5;
        halt_stb = h; stop_stb = s; ce_pin = c; wake_req = w;
    endtask

    task automatic idle(input bit c, input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, c, 1'b0);
    endtask

    initial begin
        #2000000;
        n_checks++; n_fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #5 rst_n = 1'b1;
        idle(1, 2);
        step(0, 0, 1, 1); idle(1, 1);          // R8 wake in RUN ignored
        step(1, 0, 1, 0); idle(1, 2);          // R2 halt, ce high
        step(0, 0, 0, 0); idle(0, 1);          // R6 pll follows ce in HALT
        step(0, 1, 0, 0); step(1, 0, 1, 0);    // R10 strobes in HALT
        step(0, 0, 1, 1); idle(1, 1);          // R8 leave HALT
        step(0, 1, 1, 0); idle(1, 2);          // R3 stop with ce high
        step(0, 1, 0, 0); idle(0, 3);          // R4/R5 enter CSTOP
        step(1, 0, 0, 0); step(0, 1, 0, 0);    // R10 strobes in CSTOP
        idle(1, 1);
        step(0, 0, 0, 1); idle(0, 1);          // R8 leave CSTOP
        step(1, 1, 1, 0); idle(1, 2);          // R9 both, ce high
        step(1, 1, 0, 0); idle(0, 2);          // R9 both, ce low
        step(0, 0, 1, 1); idle(1, 1);
        step(1, 0, 1, 0); idle(1, 1);
        @(posedge clk); #5 rst_n = 1'b0;       // R1 reset from HALT
        idle(1, 2);
        #0 rst_n = 1'b1;
        idle(1, 1);
        for (int i = 0; i < 2000; i++) begin
            int r;
            r = $urandom_range(0, 15);
            step(r[0] & r[1], r[2] & r[3] & ~r[0], $urandom_range(0, 1) == 1,
                 $urandom_range(0, 5) == 0);
        end
        idle(1, 3);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule